// File: doc/BRIEF.md
# Masked Fault Flag Aggregator

This block gathers a set of fault events into a register of sticky, active-low detailed flags and drives one latched, active-low summary flag. A fault event pulls its detailed flag to 0 at the next clock edge. The flag then stays at 0 until the host writes 1 to that bit after the fault has gone away. A per-flag mask register decides which detailed flags can pull the summary flag low. A masked flag still latches and still reads back.

The host sees the block as three registers: status, mask and summary. Status and summary are write-1-to-clear. The mask is loaded directly. The summary flag has an ordering rule. A write of 1 to it only takes effect in a cycle where every detailed flag already reads 1. Until then, the summary stays at 0. All outputs are registered, and the reset is synchronous and active-high.

Top module: `fault_flag_agg`

## Requirements
- R1: After reset, every status bit reads 1, every mask bit reads 0 and the summary flag reads 1.
- R2: A fault event on input bit i drives status bit i to 0 at the next rising clock edge.
- R3: A status bit at 0 stays at 0 across later edges when no write of 1 targets it, even after its event input returns to 0.
- R4: Writing 1 to a status bit sets it to 1 at the next edge only if its event input is inactive in that cycle; an active event wins and the bit stays at 0.
- R5: Writing 0 to any status bit or to the summary flag leaves that flag unchanged.
- R6: A mask write loads the written value into the mask register at the next edge, and the mask readback shows it.
- R7: A fault on a masked flag still drives its status bit to 0.
- R8: The summary flag reads 0 from the edge that follows any cycle in which a status bit reads 0 while its mask bit is 0.
- R9: A write of 1 to the summary flag sets it to 1 only in a cycle where every status bit reads 1; otherwise the summary stays at 0.
- R10: Once at 0, the summary flag stays at 0 until a valid clear, even if the contributing flag is masked afterwards.
- R11: A status bit at 0 whose mask bit is 1 never pulls a summary flag that reads 1 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fault_evt | input | NUM_FLAGS | Fault event per flag, active high |
| stat_wr_en | input | 1 | Status register write strobe |
| stat_wr_data | input | NUM_FLAGS | Status write data; a 1 clears that flag back to 1 |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | NUM_FLAGS | New mask value; 1 masks that flag from the summary |
| sum_wr_en | input | 1 | Summary flag write strobe |
| sum_wr_data | input | 1 | Summary write data; a 1 requests a clear |
| stat_rd | output | NUM_FLAGS | Detailed flags, active low |
| mask_rd | output | NUM_FLAGS | Mask readback |
| sum_rd | output | 1 | Summary flag, active low |

## Verification
The bench builds the block with NUM_FLAGS = 4, the default width. At this width all sixteen status and mask patterns are reachable in a short random sweep. That sweep covers an event that collides with a clear of the same bit, a summary clear attempted while one flag is still low, and a contributing flag masked after the summary has latched. Directed steps cover each of these cases on purpose before the random part runs.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned FA_DEF_FLAGS = 4;
  localparam logic FLAG_CLEAR = 1'b1;
  localparam logic FLAG_FAULT = 1'b0;
endpackage

// File: rtl/fa_flag_cell.sv
module fa_flag_cell
  import fa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr_req,
  output logic flag_n
);
  always_ff @(posedge clk) begin
    if (rst)          flag_n <= FLAG_CLEAR;
    else if (evt)     flag_n <= FLAG_FAULT;
    else if (clr_req) flag_n <= FLAG_CLEAR;
  end

  p_evt_latches_r2: assert property (@(posedge clk) disable iff (rst)
    evt |=> (flag_n == FLAG_FAULT));
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_n == FLAG_FAULT && !clr_req) |=> (flag_n == FLAG_FAULT));
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !evt) |=> (flag_n == FLAG_CLEAR));
endmodule

// File: rtl/fa_mask_reg.sv
module fa_mask_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end

  p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mask_q == $past(wr_data)));
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/fa_summary_flag.sv
module fa_summary_flag
  import fa_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] stat_n,
  input  logic [WIDTH-1:0] mask,
  input  logic             clr_req,
  output logic             sum_n
);
  localparam logic [WIDTH-1:0] ALL_CLEAR = '1;

  logic raise;
  logic clr_ok;

  assign raise  = |(~stat_n & ~mask);
  assign clr_ok = clr_req && (stat_n == ALL_CLEAR);

  always_ff @(posedge clk) begin
    if (rst)         sum_n <= FLAG_CLEAR;
    else if (raise)  sum_n <= FLAG_FAULT;
    else if (clr_ok) sum_n <= FLAG_CLEAR;
  end

  p_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (|(~stat_n & ~mask)) |=> (sum_n == FLAG_FAULT));
  p_clear_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (sum_n == FLAG_FAULT && stat_n != ALL_CLEAR) |=> (sum_n == FLAG_FAULT));
  p_latched_r10: assert property (@(posedge clk) disable iff (rst)
    (sum_n == FLAG_FAULT && !clr_req) |=> (sum_n == FLAG_FAULT));
  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (sum_n == FLAG_CLEAR && ((stat_n | mask) == ALL_CLEAR)) |=> (sum_n == FLAG_CLEAR));
endmodule

// File: rtl/fault_flag_agg.sv
module fault_flag_agg
  import fa_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = FA_DEF_FLAGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] fault_evt,
  input  logic                 stat_wr_en,
  input  logic [NUM_FLAGS-1:0] stat_wr_data,
  input  logic                 mask_wr_en,
  input  logic [NUM_FLAGS-1:0] mask_wr_data,
  input  logic                 sum_wr_en,
  input  logic                 sum_wr_data,
  output logic [NUM_FLAGS-1:0] stat_rd,
  output logic [NUM_FLAGS-1:0] mask_rd,
  output logic                 sum_rd
);
  logic [NUM_FLAGS-1:0] stat_q;
  logic [NUM_FLAGS-1:0] mask_q;
  logic                 sum_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    fa_flag_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .evt     (fault_evt[g]),
      .clr_req (stat_wr_en & stat_wr_data[g]),
      .flag_n  (stat_q[g])
    );
  end

  fa_mask_reg #(.WIDTH(NUM_FLAGS)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_q  (mask_q)
  );

  fa_summary_flag #(.WIDTH(NUM_FLAGS)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .stat_n  (stat_q),
    .mask    (mask_q),
    .clr_req (sum_wr_en & sum_wr_data),
    .sum_n   (sum_q)
  );

  assign stat_rd = stat_q;
  assign mask_rd = mask_q;
  assign sum_rd  = sum_q;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stat_rd == '1 && mask_rd == '0 && sum_rd == FLAG_CLEAR));
  p_zero_write_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_wr_en && !sum_wr_data && sum_rd == FLAG_FAULT) |=> (sum_rd == FLAG_FAULT));
  p_masked_latch_r7: assert property (@(posedge clk) disable iff (rst)
    (|(fault_evt & mask_rd)) |=> (stat_rd != '1));
endmodule

// File: tb/fault_flag_agg_test.sv
module fault_flag_agg_test;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] fault_evt = '0;
  logic stat_wr_en = 1'b0;
  logic [N-1:0] stat_wr_data = '0;
  logic mask_wr_en = 1'b0;
  logic [N-1:0] mask_wr_data = '0;
  logic sum_wr_en = 1'b0;
  logic sum_wr_data = 1'b0;
  logic [N-1:0] stat_rd, mask_rd;
  logic sum_rd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_stat[N];
  int m_mask[N];
  int m_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_flag_agg #(.NUM_FLAGS(N)) uut (
    .clk(clk), .rst(rst), .fault_evt(fault_evt),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .sum_wr_en(sum_wr_en), .sum_wr_data(sum_wr_data),
    .stat_rd(stat_rd), .mask_rd(mask_rd), .sum_rd(sum_rd)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pack(int a[N]);
    int v = 0;
    for (int i = 0; i < N; i++) v = v | ((a[i] & 1) << i);
    return v;
  endfunction

  task automatic compare(string tag);
    check(tag, "stat", int'(stat_rd), pack(m_stat));
    check(tag, "mask", int'(mask_rd), pack(m_mask));
    check(tag, "sum", int'(sum_rd), m_sum);
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_stat[i] = 1; m_mask[i] = 0; end
    m_sum = 1;
  endtask

  // Inputs are driven at a falling edge; the model predicts the next state.
  task automatic step(string tag, logic [N-1:0] evt, bit sw, logic [N-1:0] sd,
                      bit mw, logic [N-1:0] md, bit cw, bit cd);
    int ns[N];
    int nm[N];
    int nsum;
    bit raise = 0;
    bit all_one = 1;
    fault_evt = evt; stat_wr_en = sw; stat_wr_data = sd;
    mask_wr_en = mw; mask_wr_data = md; sum_wr_en = cw; sum_wr_data = cd;
    for (int i = 0; i < N; i++) begin
      if (m_stat[i] == 0 && m_mask[i] == 0) raise = 1;
      if (m_stat[i] == 0) all_one = 0;
      if (evt[i]) ns[i] = 0;
      else if (sw && sd[i]) ns[i] = 1;
      else ns[i] = m_stat[i];
      nm[i] = mw ? int'(md[i]) : m_mask[i];
    end
    if (raise) nsum = 0;
    else if (cw && cd && all_one) nsum = 1;
    else nsum = m_sum;
    @(posedge clk);
    @(negedge clk);
    m_stat = ns; m_mask = nm; m_sum = nsum;
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, '0, 0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");                                   // reset state
    idle("R1");

    step("R2", 4'b0010, 0, '0, 0, '0, 0, 0);         // fault bit 1
    idle("R8");                                      // summary falls
    idle("R3");                                      // sticky
    step("R9", '0, 0, '0, 0, '0, 1, 1);              // clear refused
    step("R5", '0, 1, 4'b0000, 0, '0, 1, 0);         // zero writes ignored
    step("R4", 4'b0010, 1, 4'b0010, 0, '0, 0, 0);    // event beats clear
    step("R4", '0, 1, 4'b0010, 0, '0, 0, 0);         // clear succeeds
    step("R9", '0, 0, '0, 0, '0, 1, 1);              // now accepted
    idle("R9");

    step("R6", '0, 0, '0, 1, 4'b0001, 0, 0);         // mask bit 0
    step("R7", 4'b0001, 0, '0, 0, '0, 0, 0);         // masked fault latches
    idle("R11");
    idle("R11");

    step("R2", 4'b0100, 0, '0, 0, '0, 0, 0);         // unmasked bit 2
    idle("R8");
    step("R10", '0, 0, '0, 1, 4'b0101, 0, 0);        // mask it afterwards
    idle("R10");
    step("R9", '0, 0, '0, 0, '0, 1, 1);              // still flags low
    step("R4", '0, 1, 4'b0101, 0, '0, 0, 0);
    step("R9", '0, 0, '0, 0, '0, 1, 1);
    step("R6", '0, 0, '0, 1, 4'b0000, 0, 0);
    idle("R11");

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] e;
      e = '0;
      for (int i = 0; i < N; i++) e[i] = ($urandom % 8) == 0;
      step("R2/R4/R8/R9 sweep", e, ($urandom % 3) == 0, N'($urandom),
           ($urandom % 6) == 0, N'($urandom), ($urandom % 3) == 0, 1'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule